// File: doc/BRIEF.md
# Programming-mode address sequencer

This block is the location counter on the target side of a serial program/verify test mode. It watches a digital copy of the high-voltage reset qualifier and two data-pin inputs. When the qualifier rises while both data pins are low, the block enters programming mode. In that mode it tracks which storage location is selected, and the location moves on each increment-address command.

After entry the selected location is the configuration word. This word lies outside the numbered address space. The first increment selects user address zero. Later increments walk up through user memory. An increment taken at the top of user memory selects a separate test region, and inside that region an offset counts up and stops at its last entry. When the qualifier drops, the block leaves the mode and goes back to selecting the configuration word.

The serial command decoder, the memory array and the analog level detector sit outside this block. The decoder delivers one `incr_i` pulse per increment command.

Top module: `pgm_addr_seq`

## Requirements
- R1: While reset is held and just after it is released, `prog_mode_o`, `cfg_sel_o` and `test_sel_o` are 0, and `user_addr_o` and `test_off_o` are 0.
- R2: Suppose `hv_i` was low at one clock edge and is high at the next edge, with `data0_i` and `data1_i` both low at that edge. Then after that edge `prog_mode_o` and `cfg_sel_o` are 1, `test_sel_o` is 0 and `user_addr_o` is 0.
- R3: If `hv_i` rises while either data pin is high, the block does not enter the mode. It stays out, and increments have no effect, until `hv_i` falls and rises again with both data pins low.
- R4: In programming mode, an `incr_i` high at an edge while the configuration word is selected makes `cfg_sel_o` 0, `test_sel_o` 0 and `user_addr_o` 0 after that edge.
- R5: When a user address below USER_WORDS-1 is selected, each edge with `incr_i` high adds exactly one to `user_addr_o`. An edge with `incr_i` low leaves it unchanged.
- R6: An increment taken at user address USER_WORDS-1 sets `test_sel_o` to 1 with `test_off_o` 0 and `user_addr_o` 0. USER_WORDS is 512 or 1024.
- R7: While `test_sel_o` is 1, each increment adds one to `test_off_o` until it reaches TEST_WORDS-1. After that it stays at TEST_WORDS-1.
- R8: An edge with `hv_i` low while in the mode clears `prog_mode_o`, `cfg_sel_o`, `test_sel_o`, `user_addr_o` and `test_off_o` after that edge. An increment at that same edge is ignored. A later entry selects the configuration word again.
- R9: `incr_i` is ignored while the block is out of the mode, including the edge at which entry happens. The first location after entry is always the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hv_i | input | 1 | Digital high-voltage reset qualifier |
| data0_i | input | 1 | First data-pin level, sampled at qualifier rise |
| data1_i | input | 1 | Second data-pin level, sampled at qualifier rise |
| incr_i | input | 1 | Increment-address command, one step per high cycle |
| prog_mode_o | output | 1 | Programming mode active |
| cfg_sel_o | output | 1 | Configuration word selected |
| user_addr_o | output | $clog2(USER_WORDS) | Selected user address, 0 outside user memory |
| test_sel_o | output | 1 | Special test region selected |
| test_off_o | output | $clog2(TEST_WORDS) | Offset inside the test region |

## Verification
A wrong region state shows up one edge after the increment that caused it. Either the one-hot pair `cfg_sel_o`/`test_sel_o` takes an unexpected value, or `user_addr_o` fails to follow the running count. A skipped or doubled step in the user counter stays visible at every later address, so a full walk of all 512 user addresses finds it at once. A wrong wrap into the test region or a missing saturation shows within a few cycles of the top address. A stale state after exit shows only at the next entry, which is why the bench re-enters after each exit.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic [1:0] {
    LOC_CFG  = 2'd0,
    LOC_USER = 2'd1,
    LOC_TEST = 2'd2
  } loc_region_e;
endpackage

// File: rtl/pgm_entry_det.sv
module pgm_entry_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hv_i,
  input  logic data0_i,
  input  logic data1_i,
  output logic mode_o,
  output logic leave_o
);
  logic hv_q, mode_q, enter;

  assign enter = hv_i & ~hv_q & ~data0_i & ~data1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      hv_q <= hv_i;
      if (!hv_i)      mode_q <= 1'b0;
      else if (enter) mode_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign leave_o = mode_q & ~hv_i;

  assert_entry_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(hv_i && !data0_i && !data1_i));
  assert_exit_on_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !hv_i) |=> !mode_q);
endmodule

// File: rtl/pgm_loc_ctr.sv
module pgm_loc_ctr
  import pgm_seq_pkg::*;
#(
  parameter int USER_WORDS = 512,
  parameter int TEST_WORDS = 16,
  localparam int AW = $clog2(USER_WORDS),
  localparam int TW = (TEST_WORDS > 1) ? $clog2(TEST_WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          leave_i,
  input  logic          incr_i,
  output loc_region_e   region_o,
  output logic [AW-1:0] uaddr_o,
  output logic [TW-1:0] toff_o
);
  localparam logic [AW-1:0] U_LAST = AW'(USER_WORDS - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TEST_WORDS - 1);

  loc_region_e   region_q;
  logic [AW-1:0] uaddr_q;
  logic [TW-1:0] toff_q;
  logic          active, step;

  assign active = mode_i & ~leave_i;
  assign step   = active & incr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= LOC_CFG;
      uaddr_q  <= '0;
      toff_q   <= '0;
    end else if (!active) begin
      region_q <= LOC_CFG;
      uaddr_q  <= '0;
      toff_q   <= '0;
    end else if (step) begin
      unique case (region_q)
        LOC_CFG: begin
          region_q <= LOC_USER;
          uaddr_q  <= '0;
        end
        LOC_USER: begin
          if (uaddr_q == U_LAST) begin
            region_q <= LOC_TEST;
            uaddr_q  <= '0;
            toff_q   <= '0;
          end else begin
            uaddr_q <= uaddr_q + 1'b1;
          end
        end
        LOC_TEST: if (toff_q != T_LAST) toff_q <= toff_q + 1'b1;
        default:  region_q <= LOC_CFG;
      endcase
    end
  end

  assign region_o = region_q;
  assign uaddr_o  = uaddr_q;
  assign toff_o   = toff_q;

  assert_cfg_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && region_q == LOC_CFG) |=> (region_q == LOC_USER && uaddr_q == '0));
  assert_user_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && region_q == LOC_USER && uaddr_q != U_LAST) |=> (uaddr_q == $past(uaddr_q) + 1'b1));
  assert_wrap_to_test_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && region_q == LOC_USER && uaddr_q == U_LAST) |=> (region_q == LOC_TEST && toff_q == '0));
  assert_test_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_q == LOC_TEST && toff_q == T_LAST && active) |=> (toff_q == T_LAST));
  assert_idle_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i) |=> (region_q == LOC_CFG));
endmodule

// File: rtl/pgm_addr_seq.sv
module pgm_addr_seq
  import pgm_seq_pkg::*;
#(
  parameter int USER_WORDS = 512,
  parameter int TEST_WORDS = 16,
  localparam int AW = $clog2(USER_WORDS),
  localparam int TW = (TEST_WORDS > 1) ? $clog2(TEST_WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hv_i,
  input  logic          data0_i,
  input  logic          data1_i,
  input  logic          incr_i,
  output logic          prog_mode_o,
  output logic          cfg_sel_o,
  output logic [AW-1:0] user_addr_o,
  output logic          test_sel_o,
  output logic [TW-1:0] test_off_o
);
  logic          mode, leave;
  loc_region_e   region;
  logic [AW-1:0] uaddr;
  logic [TW-1:0] toff;

  pgm_entry_det u_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hv_i    (hv_i),
    .data0_i (data0_i),
    .data1_i (data1_i),
    .mode_o  (mode),
    .leave_o (leave)
  );

  pgm_loc_ctr #(
    .USER_WORDS (USER_WORDS),
    .TEST_WORDS (TEST_WORDS)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .leave_i  (leave),
    .incr_i   (incr_i),
    .region_o (region),
    .uaddr_o  (uaddr),
    .toff_o   (toff)
  );

  assign prog_mode_o = mode;
  assign cfg_sel_o   = mode && (region == LOC_CFG);
  assign test_sel_o  = mode && (region == LOC_TEST);
  assign user_addr_o = (region == LOC_USER) ? uaddr : '0;
  assign test_off_o  = (region == LOC_TEST) ? toff : '0;

  assert_flags_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_sel_o, test_sel_o}));
endmodule

// File: tb/pgm_addr_seq_tb.sv
`timescale 1ns/1ps
module pgm_addr_seq_tb;
  localparam int UW = 512;
  localparam int TWD = 16;
  localparam int AW = $clog2(UW);
  localparam int TW = $clog2(TWD);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv = 1'b0, d0 = 1'b0, d1 = 1'b0, incr = 1'b0;
  logic prog_mode, cfg_sel, test_sel;
  logic [AW-1:0] uaddr;
  logic [TW-1:0] toff;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgm_addr_seq #(.USER_WORDS(UW), .TEST_WORDS(TWD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hv_i(hv), .data0_i(d0), .data1_i(d1),
    .incr_i(incr), .prog_mode_o(prog_mode), .cfg_sel_o(cfg_sel),
    .user_addr_o(uaddr), .test_sel_o(test_sel), .test_off_o(toff)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(string req, int pm, int cs, int ts, int ua, int to);
    chk({req, " prog_mode"}, int'(prog_mode), pm);
    chk({req, " cfg_sel"}, int'(cfg_sel), cs);
    chk({req, " test_sel"}, int'(test_sel), ts);
    chk({req, " user_addr"}, int'(uaddr), ua);
    chk({req, " test_off"}, int'(toff), to);
  endtask

  task automatic enter();
    hv = 1'b0; d0 = 1'b0; d1 = 1'b0;
    cyc();
    hv = 1'b1;
    cyc();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk_state("R1 in reset", int'(prog_mode), 0, 0, 0, 0);
    chk("R1 in reset prog_mode", int'(prog_mode), 0);
    cyc();
    rst_n = 1'b1;
    cyc();
    chk_state("R1 after reset", 0, 0, 0, 0, 0);

    // R9: increments out of mode
    incr = 1'b1;
    repeat (3) cyc();
    chk_state("R9 idle incr", 0, 0, 0, 0, 0);

    // R3: rise with a data pin high
    incr = 1'b0; d0 = 1'b1; hv = 1'b1;
    cyc();
    chk_state("R3 d0 high", 0, 0, 0, 0, 0);
    d0 = 1'b0; incr = 1'b1;
    cyc();
    chk_state("R3 no late entry", 0, 0, 0, 0, 0);
    incr = 1'b0; hv = 1'b0;
    cyc();
    d1 = 1'b1; hv = 1'b1;
    cyc();
    chk_state("R3 d1 high", 0, 0, 0, 0, 0);
    d1 = 1'b0; hv = 1'b0;
    cyc();

    // R2 with R9: incr at entry edge ignored
    hv = 1'b1; incr = 1'b1;
    cyc();
    incr = 1'b0;
    chk_state("R2/R9 entry", 1, 1, 0, 0, 0);
    d0 = 1'b1; d1 = 1'b1;
    cyc();
    chk_state("R2 pins free after entry", 1, 1, 0, 0, 0);

    // R4/R5: full user walk with incr held
    incr = 1'b1;
    for (int i = 0; i < UW; i++) begin
      cyc();
      if (i == 0) chk_state("R4 first incr", 1, 0, 0, 0, 0);
      else begin
        chk("R5 user_addr", int'(uaddr), i);
        chk("R5 cfg_sel", int'(cfg_sel), 0);
        chk("R5 test_sel", int'(test_sel), 0);
      end
    end
    incr = 1'b0;
    cyc();
    chk("R5 hold without incr", int'(uaddr), UW - 1);

    // R6 and R7
    incr = 1'b1;
    cyc();
    chk_state("R6 wrap to test", 1, 0, 1, 0, 0);
    for (int k = 1; k <= TWD + 4; k++) begin
      cyc();
      chk("R7 test_off", int'(toff), (k < TWD - 1) ? k : TWD - 1);
      chk("R7 test_sel", int'(test_sel), 1);
    end

    // R8: exit with incr high at the exit edge
    hv = 1'b0;
    cyc();
    chk_state("R8 exit", 0, 0, 0, 0, 0);
    incr = 1'b0; d0 = 1'b0; d1 = 1'b0;
    enter();
    chk_state("R8 re-entry", 1, 1, 0, 0, 0);

    // R8: exit from mid user memory
    incr = 1'b1;
    repeat (5) cyc();
    incr = 1'b0;
    chk("R5 partial walk", int'(uaddr), 4);
    hv = 1'b0;
    cyc();
    chk_state("R8 exit mid user", 0, 0, 0, 0, 0);
    enter();
    chk_state("R8 re-entry mid", 1, 1, 0, 0, 0);
    incr = 1'b1;
    cyc();
    incr = 1'b0;
    chk_state("R4 after re-entry", 1, 0, 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule